// File: doc/BRIEF.md
# Sectioned Cubic Coefficient Extractor

This block reduces a converter's integral-nonlinearity curve to four cubic coefficients, so that a calibration path never has to store one error value per code. A test controller pulses `start` and then presents one signed INL sample per code with `samp_valid`, ascending from the lowest code to the highest. The block counts accepted samples. It splits the 2^CODE_W codes into four equal consecutive quarters and keeps one running sum per quarter.

When the final code has been accepted, the block works through a short fixed sequence. It first forms four weighted combinations of the quarter sums. It then turns these into the numerators of the coefficients of y = b0 + b1·x + b2·x² + b3·x³. Here x is the code divided by the number of codes, so it runs over [0, 1), and y is in INL sample units. Finally it scales each numerator into a fixed-point coefficient with FRAC_W fractional bits, one coefficient per cycle, using only shifts, adds and one shared divide-by-three. A single-cycle `coeff_valid` pulse announces the result. The coefficients then hold until the next run completes.

Top module: `cubic_coef_extract`

## Requirements
- R1: While `rst_n` is low at a clock edge, `coeff_valid` and all four coefficient outputs clear to zero.
- R2: A high `start` at a clock edge discards any partial run, clears the quarter sums and the code count, and opens a ramp that ends after exactly 2^CODE_W accepted samples.
- R3: An accepted sample with zero-based position k in the ramp goes to quarter sum S[k >> (CODE_W-2)], so positions 0 to M-1 feed S0, M to 2M-1 feed S1, and so on, with M = 2^CODE_W/4.
- R4: The combination terms are P0 = S0+S1+S2+S3, P1 = S3+S2-S1-S0, P2 = S3-S2-S1+S0 and P3 = S3-3·S2+3·S1-S0.
- R5: b3 = ((32·P3) >>> SH) / 3, where SH = CODE_W-2-FRAC_W.
- R6: b2 = (4·P2 - 16·P3) >>> SH.
- R7: b1 = ((3·P1 - 12·P2 + 20·P3) >>> SH) / 3.
- R8: b0 = ((3·P0 - 6·P1 + 8·P2 - 8·P3) >>> (SH+2)) / 3.
- R9: Every >>> is an arithmetic shift that rounds toward minus infinity. Every / 3 truncates toward zero, including for negative operands.
- R10: `coeff_valid` is high for exactly one cycle, first visible after the sixth rising edge that follows the edge accepting the final sample. The coefficients already hold the new values in that cycle and stay unchanged until the next run finishes scaling.
- R11: A sample presented while `samp_valid` is low, or while no ramp is open, is not counted and does not enter any sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Opens a new ramp and discards any partial one |
| samp_valid | input | 1 | Qualifies `samp_inl` for the current cycle |
| samp_inl | input | SAMP_W | Signed INL sample of the current code |
| coeff_valid | output | 1 | One-cycle pulse when new coefficients are in place |
| coef_b0 | output | SAMP_W+CODE_W+7 | Signed constant coefficient, FRAC_W fractional bits |
| coef_b1 | output | SAMP_W+CODE_W+7 | Signed linear coefficient, FRAC_W fractional bits |
| coef_b2 | output | SAMP_W+CODE_W+7 | Signed quadratic coefficient, FRAC_W fractional bits |
| coef_b3 | output | SAMP_W+CODE_W+7 | Signed cubic coefficient, FRAC_W fractional bits |

## Verification
The bench builds the block with CODE_W = 6, SAMP_W = 8 and FRAC_W = 2. That gives a 64-code ramp with 16 codes per quarter and a scaling shift of two, so a full run takes well under a hundred cycles. Many runs fit in one bench: constant, linear, cubic-like, negative, gapped and restarted inputs. A single spike can be placed on either side of a quarter boundary to show which sum it lands in. Because the shift is small, many remainder bits reach the divide-by-three, and negative numerators make the truncation-toward-zero rule visible in the outputs.

// File: rtl/cx_pkg.sv
// Shared types of the cubic coefficient extractor.
package cx_pkg;

    // Sequencer states: idle, collecting the ramp, forming terms,
    // forming numerators, scaling one coefficient per cycle.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RAMP  = 3'd1,
        ST_COMB  = 3'd2,
        ST_NUMS  = 3'd3,
        ST_SCALE = 3'd4
    } cx_state_e;

endpackage

// File: rtl/cx_section_accum.sv
// Quarter accumulators with the code counter.
// Counts accepted samples. The top two bits of the count pick which of
// the four running sums takes the sample. Assumes CODE_W >= 3 and that
// the caller raises `accept` only inside an open ramp.
module cx_section_accum #(
    parameter int CODE_W = 14,
    parameter int SAMP_W = 12,
    localparam int SUM_W = SAMP_W + CODE_W - 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     accept,
    input  logic signed [SAMP_W-1:0] samp,
    output logic        [CODE_W-1:0] cnt,
    output logic                     last_code,
    output logic signed [SUM_W-1:0]  sums [4]
);

    logic [1:0] sect;

    assign sect      = cnt[CODE_W-1 -: 2];
    assign last_code = (cnt == {CODE_W{1'b1}});

    // Advance the count by one for every accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clear)  cnt <= '0;
        else if (accept) cnt <= cnt + 1'b1;
    end

    for (genvar g = 0; g < 4; g++) begin : g_quarter
        logic signed [SUM_W-1:0] acc_q;

        // Add the sample into this quarter's sum when the count lies in it.
        always_ff @(posedge clk) begin
            if (!rst_n)                           acc_q <= '0;
            else if (clear)                       acc_q <= '0;
            else if (accept && (sect == 2'(g)))   acc_q <= acc_q + SUM_W'(samp);
        end

        assign sums[g] = acc_q;
    end

endmodule

// File: rtl/cx_combine.sv
// Fixed add/subtract networks of the extractor.
// Path one turns the quarter sums into the four combination terms.
// Path two turns registered terms into the coefficient numerators.
// Both paths are purely combinational. Widths leave room for the
// largest weight in each path, so nothing overflows.
module cx_combine #(
    parameter int SUM_W = 24,
    localparam int B_W   = SUM_W + 3,
    localparam int NUM_W = B_W + 6
) (
    input  logic signed [SUM_W-1:0] sums    [4],
    input  logic signed [B_W-1:0]   b_in    [4],
    output logic signed [B_W-1:0]   b_out   [4],
    output logic signed [NUM_W-1:0] num_out [4]
);

    logic signed [B_W-1:0]   s0, s1, s2, s3;
    logic signed [NUM_W-1:0] p0, p1, p2, p3;

    // Widen the quarter sums and form the combination terms.
    always_comb begin
        s0 = B_W'(sums[0]);
        s1 = B_W'(sums[1]);
        s2 = B_W'(sums[2]);
        s3 = B_W'(sums[3]);
        b_out[0] = s0 + s1 + s2 + s3;
        b_out[1] = s3 + s2 - s1 - s0;
        b_out[2] = s3 - s2 - s1 + s0;
        b_out[3] = s3 - ((s2 <<< 1) + s2) + ((s1 <<< 1) + s1) - s0;
    end

    // Widen the terms and form the numerators with shift-and-add weights.
    always_comb begin
        p0 = NUM_W'(b_in[0]);
        p1 = NUM_W'(b_in[1]);
        p2 = NUM_W'(b_in[2]);
        p3 = NUM_W'(b_in[3]);
        num_out[3] = p3 <<< 5;
        num_out[2] = (p2 <<< 2) - (p3 <<< 4);
        num_out[1] = (p1 <<< 1) + p1 - (p2 <<< 3) - (p2 <<< 2)
                   + (p3 <<< 4) + (p3 <<< 2);
        num_out[0] = (p0 <<< 1) + p0 - (p1 <<< 2) - (p1 <<< 1)
                   + (p2 <<< 3) - (p3 <<< 3);
    end

endmodule

// File: rtl/cx_third_div.sv
// Exact signed division by three, truncating toward zero.
// Takes the magnitude, multiplies it by a reciprocal constant and
// restores the sign. With an even shift S >= W+2, the quotient is exact
// for every W-bit magnitude.
module cx_third_div #(
    parameter int W = 16,
    localparam int S = W + (W % 2) + 2
) (
    input  logic signed [W-1:0] x,
    output logic signed [W-1:0] q
);

    localparam longint unsigned RECIP_L = ((64'd1 << S) + 64'd2) / 64'd3;
    localparam logic [S-1:0]    RECIP   = S'(RECIP_L);

    logic [W-1:0]   mag;
    logic [W+S-1:0] prod;
    logic [W-1:0]   quo;

    // Divide the magnitude by the reciprocal multiply, then reapply the sign.
    always_comb begin
        mag  = x[W-1] ? W'(-x) : W'(x);
        prod = {{S{1'b0}}, mag} * {{W{1'b0}}, RECIP};
        quo  = prod[W+S-1:S];
        q    = x[W-1] ? -$signed(quo) : $signed(quo);
    end

endmodule

// File: rtl/cubic_coef_extract.sv
// Sectioned cubic coefficient extractor, top level.
// Collects one ramp of 2^CODE_W INL samples into four quarter sums.
// After the final code it spends one cycle on the combination terms,
// one on the numerators and four on scaling, one coefficient each.
// Then it pulses coeff_valid. Assumes FRAC_W <= CODE_W-2 and CODE_W >= 3.
module cubic_coef_extract
    import cx_pkg::*;
#(
    parameter int CODE_W = 14,
    parameter int SAMP_W = 12,
    parameter int FRAC_W = 8,
    localparam int COEF_W = SAMP_W + CODE_W + 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     samp_valid,
    input  logic signed [SAMP_W-1:0] samp_inl,
    output logic                     coeff_valid,
    output logic signed [COEF_W-1:0] coef_b0,
    output logic signed [COEF_W-1:0] coef_b1,
    output logic signed [COEF_W-1:0] coef_b2,
    output logic signed [COEF_W-1:0] coef_b3
);

    localparam int SUM_W = SAMP_W + CODE_W - 2;
    localparam int B_W   = SUM_W + 3;
    localparam int NUM_W = B_W + 6;
    localparam int SH    = CODE_W - 2 - FRAC_W;

    if (FRAC_W > CODE_W - 2) begin : g_bad_frac
        $error("FRAC_W must not exceed CODE_W-2");
    end

    cx_state_e               state_q;
    logic [1:0]              idx_q;
    logic                    valid_q;
    logic                    accept;
    logic                    last_code;
    logic [CODE_W-1:0]       cnt;
    logic signed [SUM_W-1:0] sums     [4];
    logic signed [B_W-1:0]   b_comb   [4];
    logic signed [B_W-1:0]   b_q      [4];
    logic signed [NUM_W-1:0] num_comb [4];
    logic signed [NUM_W-1:0] num_q    [4];
    logic signed [NUM_W-1:0] coef_q   [4];
    logic signed [NUM_W-1:0] num_sel;
    logic signed [NUM_W-1:0] shifted;
    logic signed [NUM_W-1:0] third;
    logic signed [NUM_W-1:0] scaled;

    assign accept = samp_valid && (state_q == ST_RAMP) && !start;

    cx_section_accum #(
        .CODE_W (CODE_W),
        .SAMP_W (SAMP_W)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .accept    (accept),
        .samp      (samp_inl),
        .cnt       (cnt),
        .last_code (last_code),
        .sums      (sums)
    );

    cx_combine #(
        .SUM_W (SUM_W)
    ) u_comb (
        .sums    (sums),
        .b_in    (b_q),
        .b_out   (b_comb),
        .num_out (num_comb)
    );

    // Pick this cycle's numerator and apply its shift; b0 takes two extra.
    always_comb begin
        num_sel = num_q[idx_q];
        shifted = (idx_q == 2'd0) ? (num_sel >>> (SH + 2)) : (num_sel >>> SH);
        scaled  = (idx_q == 2'd2) ? shifted : third;
    end

    cx_third_div #(
        .W (NUM_W)
    ) u_div (
        .x (shifted),
        .q (third)
    );

    // Step the sequencer; start overrides every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (start) begin
            state_q <= ST_RAMP;
        end else begin
            case (state_q)
                ST_RAMP:  if (accept && last_code) state_q <= ST_COMB;
                ST_COMB:  state_q <= ST_NUMS;
                ST_NUMS:  state_q <= ST_SCALE;
                ST_SCALE: if (idx_q == 2'd3) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Register the combination terms and numerators, and walk the index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            for (int i = 0; i < 4; i++) begin
                b_q[i]   <= '0;
                num_q[i] <= '0;
            end
        end else if (!start) begin
            if (state_q == ST_COMB) b_q <= b_comb;
            if (state_q == ST_NUMS) begin
                num_q <= num_comb;
                idx_q <= '0;
            end
            if (state_q == ST_SCALE) idx_q <= idx_q + 2'd1;
        end
    end

    // Write each scaled coefficient; pulse valid with the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            for (int i = 0; i < 4; i++) coef_q[i] <= '0;
        end else begin
            valid_q <= 1'b0;
            if (!start && state_q == ST_SCALE) begin
                coef_q[idx_q] <= scaled;
                if (idx_q == 2'd3) valid_q <= 1'b1;
            end
        end
    end

    assign coeff_valid = valid_q;
    assign coef_b0     = coef_q[0];
    assign coef_b1     = coef_q[1];
    assign coef_b2     = coef_q[2];
    assign coef_b3     = coef_q[3];

endmodule

// File: rtl/cubic_coef_extract_checker.sv
// Temporal checks on the extractor's sequencing, attached by bind.
// Observes ports plus the sequencer state and the code count.
module cx_checker
    import cx_pkg::*;
#(
    parameter int CODE_W = 14,
    parameter int COEF_W = 33
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              samp_valid,
    input logic              coeff_valid,
    input cx_state_e         state,
    input logic [CODE_W-1:0] cnt,
    input logic [COEF_W-1:0] b0,
    input logic [COEF_W-1:0] b1,
    input logic [COEF_W-1:0] b2,
    input logic [COEF_W-1:0] b3
);

    // R10: the done flag never lasts longer than one cycle.
    assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        coeff_valid |=> !coeff_valid);

    // R10: the done flag only rises straight out of scaling.
    assert_valid_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coeff_valid) |-> $past(state) == ST_SCALE);

    // R10: coefficients hold while the sequencer is idle.
    assert_coef_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> $stable({b0, b1, b2, b3}));

    // R2: start clears the count and opens a ramp without a done pulse.
    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt == '0) && (state == ST_RAMP) && !coeff_valid);

    // R11: samples do not leave the idle state without start.
    assert_idle_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> (state == ST_IDLE));

    // R11: an unqualified cycle inside a ramp does not advance the count.
    assert_gap_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RAMP && !samp_valid && !start) |=> $stable(cnt));

endmodule

bind cubic_coef_extract cx_checker #(
    .CODE_W (CODE_W),
    .COEF_W (COEF_W)
) u_cx_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .samp_valid  (samp_valid),
    .coeff_valid (coeff_valid),
    .state       (state_q),
    .cnt         (cnt),
    .b0          (coef_b0),
    .b1          (coef_b1),
    .b2          (coef_b2),
    .b3          (coef_b3)
);

// File: tb/cubic_coef_extract_bench.sv
`timescale 1ns/1ps
// Directed bench for the cubic coefficient extractor.
module cubic_coef_extract_bench;

    localparam int CODE_W = 6;
    localparam int SAMP_W = 8;
    localparam int FRAC_W = 2;
    localparam int N      = 1 << CODE_W;
    localparam int M      = N / 4;
    localparam int SH     = CODE_W - 2 - FRAC_W;
    localparam int CW     = SAMP_W + CODE_W + 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic samp_valid = 1'b0;
    logic signed [SAMP_W-1:0] samp_inl = '0;
    logic coeff_valid;
    logic signed [CW-1:0] coef_b0, coef_b1, coef_b2, coef_b3;

    int     n_chk = 0;
    int     n_bad = 0;
    bit     done  = 1'b0;
    int     smp [N];
    longint exp_b [4];

    always #2 clk = ~clk;

    cubic_coef_extract #(
        .CODE_W (CODE_W),
        .SAMP_W (SAMP_W),
        .FRAC_W (FRAC_W)
    ) u_cubic_coef_extract (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .samp_valid  (samp_valid),
        .samp_inl    (samp_inl),
        .coeff_valid (coeff_valid),
        .coef_b0     (coef_b0),
        .coef_b1     (coef_b1),
        .coef_b2     (coef_b2),
        .coef_b3     (coef_b3)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint coef_now(input int i);
        case (i)
            0:       return longint'(coef_b0);
            1:       return longint'(coef_b1);
            2:       return longint'(coef_b2);
            default: return longint'(coef_b3);
        endcase
    endfunction

    // Expected coefficients from the requirement formulas (R3, R4, R5-R9).
    task automatic compute_expected();
        longint s [4];
        longint p0, p1, p2, p3, n0, n1, n2, n3;
        for (int k = 0; k < 4; k++) s[k] = 0;
        for (int i = 0; i < N; i++) s[i / M] += smp[i];
        p0 = s[0] + s[1] + s[2] + s[3];
        p1 = s[3] + s[2] - s[1] - s[0];
        p2 = s[3] - s[2] - s[1] + s[0];
        p3 = s[3] - 3 * s[2] + 3 * s[1] - s[0];
        n3 = 32 * p3;
        n2 = 4 * p2 - 16 * p3;
        n1 = 3 * p1 - 12 * p2 + 20 * p3;
        n0 = 3 * p0 - 6 * p1 + 8 * p2 - 8 * p3;
        exp_b[0] = (n0 >>> (SH + 2)) / 3;
        exp_b[1] = (n1 >>> SH) / 3;
        exp_b[2] = n2 >>> SH;
        exp_b[3] = (n3 >>> SH) / 3;
    endtask

    function automatic int clip(input int v);
        if (v > 127)  return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    // Drive a ramp of smp[], then check the pulse timing and values (R10).
    task automatic run_ramp(input bit gaps, input string tag);
        int seen;
        seen = 0;
        compute_expected();
        @(negedge clk); start = 1'b1; samp_valid = 1'b0;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (gaps && (i % 5 == 2)) begin
                samp_valid = 1'b0; samp_inl = 8'sd99;
                @(negedge clk);
            end
            samp_valid = 1'b1; samp_inl = SAMP_W'(smp[i]);
            @(negedge clk);
        end
        samp_valid = 1'b0; samp_inl = 8'sd77;
        for (int j = 1; j <= 8; j++) begin
            if (j > 1) @(negedge clk);
            if (coeff_valid !== (j == 7)) seen++;
            if (j == 7) begin
                check({"R8 R4 ", tag}, "b0", coef_now(0), exp_b[0]);
                check({"R7 R9 ", tag}, "b1", coef_now(1), exp_b[1]);
                check({"R6 ", tag},    "b2", coef_now(2), exp_b[2]);
                check({"R5 R9 ", tag}, "b3", coef_now(3), exp_b[3]);
            end
        end
        check({"R10 ", tag}, "valid pulse timing mismatches", seen, 0);
        repeat (3) @(negedge clk);
        check({"R10 ", tag}, "b0 held", coef_now(0), exp_b[0]);
        check({"R10 ", tag}, "b3 held", coef_now(3), exp_b[3]);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "coeff_valid in reset", longint'(coeff_valid), 0);
        for (int i = 0; i < 4; i++) check("R1", "coef in reset", coef_now(i), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_constant();
        for (int i = 0; i < N; i++) smp[i] = 5;
        run_ramp(1'b0, "constant");
        check("R8", "constant b0 equals 5 with 2 frac bits", coef_now(0), 20);
    endtask

    task automatic t_linear();
        for (int i = 0; i < N; i++) smp[i] = clip((i - 32) * 2);
        run_ramp(1'b0, "linear");
    endtask

    task automatic t_cubic();
        for (int i = 0; i < N; i++) smp[i] = clip(((i - 32) * (i - 32) * (i - 32)) / 256);
        run_ramp(1'b0, "cubic");
    endtask

    task automatic t_negative();
        for (int i = 0; i < N; i++) smp[i] = -((i * 37) % 97) - 7;
        run_ramp(1'b0, "negative R9");
    endtask

    // A single spike just below and just above the first quarter boundary (R3).
    task automatic t_section_edge();
        for (int i = 0; i < N; i++) smp[i] = 0;
        smp[M - 1] = 100;
        run_ramp(1'b0, "R3 spike low");
        smp[M - 1] = 0;
        smp[M] = 100;
        run_ramp(1'b0, "R3 spike high");
        smp[M] = 0;
        smp[3 * M - 1] = -90;
        run_ramp(1'b0, "R3 spike third");
    endtask

    task automatic t_gaps();
        for (int i = 0; i < N; i++) smp[i] = ((i * 53 + 11) % 200) - 100;
        run_ramp(1'b1, "R11 gaps");
    endtask

    // A partial ramp of large samples is discarded by a second start (R2).
    task automatic t_restart();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 20; i++) begin
            samp_valid = 1'b1; samp_inl = 8'sd127;
            @(negedge clk);
        end
        samp_valid = 1'b0;
        for (int i = 0; i < N; i++) smp[i] = ((i * 29 + 3) % 61) - 30;
        run_ramp(1'b0, "R2 restart");
    endtask

    // Valid samples with no ramp open raise nothing and change nothing (R11).
    task automatic t_stray();
        int pulses;
        pulses = 0;
        for (int i = 0; i < N + 16; i++) begin
            @(negedge clk);
            samp_valid = 1'b1; samp_inl = 8'sd100;
            if (coeff_valid) pulses++;
        end
        @(negedge clk); samp_valid = 1'b0;
        repeat (8) begin
            @(negedge clk);
            if (coeff_valid) pulses++;
        end
        check("R11", "stray valid pulses", pulses, 0);
        for (int i = 0; i < 4; i++) check("R11", "coef after stray samples", coef_now(i), exp_b[i]);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_constant();
        t_linear();
        t_cubic();
        t_negative();
        t_section_edge();
        t_gaps();
        t_restart();
        t_stray();
        finish_run();
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog all-requirements: actual=timeout expected=completion");
        finish_run();
    end

endmodule